// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is an N-bit storage register, four bits wide by default, whose contents change once per rising clock edge. A two-bit operation select steers every bit at once. The register can keep its value, move all bits one place towards the right end, move them one place towards the left end, or take a whole new word from a parallel data input. A synchronous clear empties the register and wins over every operation.

The register has one serial entry port at each end, so data can stream in from either side. Both end bits are also visible as serial outputs, and the whole word is visible on a parallel output. A typical use is parallel-to-serial conversion: load a word, then shift it out one bit per cycle from one end. Another is serial-to-parallel capture: shift a bit stream in, then read the word.

The operations act as four named states of each bit's selector. They are HOLD (select 00), SHIFT_R (select 01), SHIFT_L (select 10) and LOAD (select 11). The CLEAR transition overrides all four. Bit index W-1 is the left end and bit 0 is the right end.

Top module: `univ_shreg`

## Requirements
- R1: When `clr` is 1 at a rising edge, `par_out` is all zeros after that edge, whatever the values on `mode_sel`, the serial inputs and `par_in`.
- R2: With `clr` at 0 and `mode_sel` = 2'b00 (HOLD), `par_out` keeps its value across the edge.
- R3: With `mode_sel` = 2'b01 (SHIFT_R), bit i takes the old bit i+1, and bit W-1 takes `ser_in_left`.
- R4: With `mode_sel` = 2'b10 (SHIFT_L), bit i takes the old bit i-1, and bit 0 takes `ser_in_right`.
- R5: With `mode_sel` = 2'b11 (LOAD), `par_out` takes `par_in` after the edge.
- R6: `ser_out_left` always equals `par_out[W-1]`, and `ser_out_right` always equals `par_out[0]`.
- R7: The serial input that an operation does not consume has no effect on the result. This covers `ser_in_right` in SHIFT_R, `ser_in_left` in SHIFT_L, and both serial inputs in HOLD and LOAD.
- R8: After a LOAD followed by W SHIFT_R cycles, `ser_out_right` presents the loaded word one bit per cycle, starting with bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| mode_sel | input | 2 | Operation: 00 HOLD, 01 SHIFT_R, 10 SHIFT_L, 11 LOAD |
| ser_in_left | input | 1 | Serial bit entering at bit W-1 in SHIFT_R |
| ser_in_right | input | 1 | Serial bit entering at bit 0 in SHIFT_L |
| par_in | input | W | Parallel word for LOAD |
| par_out | output | W | Stored word |
| ser_out_left | output | 1 | Stored bit W-1 |
| ser_out_right | output | 1 | Stored bit 0 |

## Verification
Every result appears exactly one rising edge after the inputs that cause it, because each bit passes through a single register stage. The serial outputs are that same stored word, so they add no further delay. The bench changes inputs on the falling edge and samples on the next falling edge, half a period after the capturing edge. It updates its arithmetic model at that same moment, so model and design describe the same edge. The parallel-to-serial check reads `ser_out_right` once per cycle in this way, so bit k of the loaded word is due k cycles after the load.

// File: rtl/univ_shreg_pkg.sv
package univ_shreg_pkg;

    // Operation select encoding; bit order of mode_sel is behaviour.
    typedef enum logic [1:0] {
        OP_HOLD    = 2'b00,
        OP_SHIFT_R = 2'b01,
        OP_SHIFT_L = 2'b10,
        OP_LOAD    = 2'b11
    } shreg_op_e;

    localparam int unsigned OP_COUNT = 4;

    // One-hot steering word produced by the decoder.
    typedef struct packed {
        logic load;
        logic shl;
        logic shr;
        logic hold;
    } shreg_steer_t;

endpackage

// File: rtl/shreg_op_decode.sv
module shreg_op_decode
    import univ_shreg_pkg::*;
(
    input  logic         clk,
    input  logic         clr,
    input  logic [1:0]   mode_sel,
    output shreg_steer_t steer
);

    shreg_op_e op;

    always_comb begin
        op    = shreg_op_e'(mode_sel);
        steer = '0;
        unique case (op)
            OP_HOLD:    steer.hold = 1'b1;
            OP_SHIFT_R: steer.shr  = 1'b1;
            OP_SHIFT_L: steer.shl  = 1'b1;
            OP_LOAD:    steer.load = 1'b1;
            default:    steer.hold = 1'b1;
        endcase
    end

    // R2 R3 R4 R5
    steer_onehot_chk: assert property (@(posedge clk) disable iff (clr)
        $onehot(steer));

endmodule

// File: rtl/shreg_bit_cell.sv
module shreg_bit_cell
    import univ_shreg_pkg::*;
(
    input  logic         clk,
    input  logic         clr,
    input  shreg_steer_t steer,
    input  logic         from_left,
    input  logic         from_right,
    input  logic         load_bit,
    output logic         q
);

    logic q_next;

    // Four-way selector: own value, left neighbour, right neighbour, load bit.
    always_comb begin
        q_next = (steer.hold & q)
               | (steer.shr  & from_left)
               | (steer.shl  & from_right)
               | (steer.load & load_bit);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
    import univ_shreg_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [1:0]   mode_sel,
    input  logic         ser_in_left,
    input  logic         ser_in_right,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out,
    output logic         ser_out_left,
    output logic         ser_out_right
);

    localparam int unsigned MSB = W - 1;

    shreg_steer_t steer;
    logic [W-1:0] bits_q;

    shreg_op_decode u_dec (
        .clk      (clk),
        .clr      (clr),
        .mode_sel (mode_sel),
        .steer    (steer)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic left_src;
        logic right_src;

        if (i == MSB) begin : g_left_end
            assign left_src = ser_in_left;
        end else begin : g_left_mid
            assign left_src = bits_q[i+1];
        end

        if (i == 0) begin : g_right_end
            assign right_src = ser_in_right;
        end else begin : g_right_mid
            assign right_src = bits_q[i-1];
        end

        shreg_bit_cell u_cell (
            .clk        (clk),
            .clr        (clr),
            .steer      (steer),
            .from_left  (left_src),
            .from_right (right_src),
            .load_bit   (par_in[i]),
            .q          (bits_q[i])
        );
    end

    assign par_out       = bits_q;
    assign ser_out_left  = bits_q[MSB];
    assign ser_out_right = bits_q[0];

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        clr |=> (par_out == '0));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (clr)
        (mode_sel == OP_HOLD) |=> $stable(par_out));

    // R3
    shift_right_chk: assert property (@(posedge clk) disable iff (clr)
        (mode_sel == OP_SHIFT_R) |=>
            (par_out == {$past(ser_in_left), $past(par_out[W-1:1])}));

    // R4
    shift_left_chk: assert property (@(posedge clk) disable iff (clr)
        (mode_sel == OP_SHIFT_L) |=>
            (par_out == {$past(par_out[W-2:0]), $past(ser_in_right)}));

    // R5
    load_word_chk: assert property (@(posedge clk) disable iff (clr)
        (mode_sel == OP_LOAD) |=> (par_out == $past(par_in)));

endmodule

// File: tb/sim_univ_shreg.sv
module sim_univ_shreg;

    localparam int unsigned W = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned WATCHDOG_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         clr;
    logic [1:0]   mode_sel;
    logic         ser_in_left;
    logic         ser_in_right;
    logic [W-1:0] par_in;
    logic [W-1:0] par_out;
    logic         ser_out_left;
    logic         ser_out_right;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    logic [W-1:0] model = '0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    univ_shreg #(.W(W)) u0 (
        .clk           (clk),
        .clr           (clr),
        .mode_sel      (mode_sel),
        .ser_in_left   (ser_in_left),
        .ser_in_right  (ser_in_right),
        .par_in        (par_in),
        .par_out       (par_out),
        .ser_out_left  (ser_out_left),
        .ser_out_right (ser_out_right)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; drives, waits one edge, samples at next falling edge.
    task automatic apply(input logic c, input logic [1:0] m, input logic sl,
                         input logic sr, input logic [W-1:0] d);
        string req;
        clr = c; mode_sel = m; ser_in_left = sl; ser_in_right = sr; par_in = d;
        @(negedge clk);
        if (c) begin
            model = '0;
            req = "R1";
        end else begin
            case (m)
                2'b00: begin model = model;                  req = "R2 R7"; end
                2'b01: begin model = {sl, model[W-1:1]};     req = "R3 R7"; end
                2'b10: begin model = {model[W-2:0], sr};     req = "R4 R7"; end
                default: begin model = d;                    req = "R5 R7"; end
            endcase
        end
        check(req, par_out, model);
        check("R6", {{(W-1){1'b0}}, ser_out_left},  {{(W-1){1'b0}}, model[W-1]});
        check("R6", {{(W-1){1'b0}}, ser_out_right}, {{(W-1){1'b0}}, model[0]});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        clr = 1'b1; mode_sel = 2'b11; ser_in_left = 1'b1; ser_in_right = 1'b1; par_in = '1;
        @(negedge clk);
        @(negedge clk);
        model = '0;
        // R1 reset state
        check("R1", par_out, '0);

        // Sweep: every start word, every operation, every serial-input pair
        for (int s = 0; s < (1 << W); s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    for (int sr = 0; sr < 2; sr++) begin
                        apply(1'b0, 2'b11, 1'b0, 1'b0, W'(s));
                        apply(1'b0, 2'(m), 1'(sl), 1'(sr), ~W'(s));
                    end
                end
            end
        end

        // R1 clear wins over every operation
        for (int m = 0; m < 4; m++) begin
            apply(1'b0, 2'b11, 1'b0, 1'b0, '1);
            apply(1'b1, 2'(m), 1'b1, 1'b1, 4'b1010);
        end

        // R8 parallel-to-serial: load then shift right W times
        apply(1'b0, 2'b11, 1'b0, 1'b0, 4'b1011);
        for (int k = 0; k < W; k++) begin
            check("R8", {{(W-1){1'b0}}, ser_out_right}, {{(W-1){1'b0}}, model[0]});
            check("R8", {{(W-1){1'b0}}, ser_out_right}, {{(W-1){1'b0}}, (4'b1011 >> k) & 1'b1});
            apply(1'b0, 2'b01, 1'b0, 1'b1, 4'b0000);
        end
        check("R8", par_out, '0);

        // Random operation sequences with occasional clear
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            apply((r[7:4] == 4'h0), r[1:0], r[2], r[3], W'($urandom));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule